// File: doc/BRIEF.md
# Accumulator Machine Fetch and Control-Flow Sequencer

This block is the instruction sequencer of a small 8-bit accumulator processor. It owns a 16-bit program counter and an 8-bit code segment register. It fetches opcodes from a synchronous code memory addressed by the segment concatenated with the program counter, and sorts each opcode into a class. Control-flow operations are carried out inside the block: stop, no-op, the debug print, the conditional and unconditional relative transfers, and the near and far calls. Every other legal opcode leaves as a one-cycle strobe to the execution units, with its immediate byte attached when it has one.

The accumulator itself lives outside the block. The sequencer reads its value to decide branches, to move by call displacements and to print. It writes the accumulator back only through a write strobe, when a call produces a return value. A stop or an illegal opcode parks the sequencer in a sticky halted state that only reset clears.

A one-byte instruction takes two cycles: an address cycle, then a decode cycle. An instruction whose upper nibble is all ones adds a third cycle to fetch its immediate.

Top module: `accseq_fetch`

## Requirements
- R1: After reset the program counter is 0, the code segment is 1, `halted` is 0, and the first memory request addresses segment 1, offset 0 (`imem_addr` = {segment, pc}).
- R2: Opcode 0x00 and every illegal opcode set `halted` permanently. The illegal opcodes are 0x04, 0x05, 0x13, 0x14–0x17, 0x1B, 0x1C–0x1F, 0xC0–0xDF, 0xF6–0xFD and 0xFF. The pc keeps the address of the offending opcode, no immediate is fetched, and no memory request or strobe is issued afterwards.
- R3: Opcode 0x01 advances the pc by 1 and raises no strobe.
- R4: Opcode 0x02 pulses `print_valid` for one cycle with `print_data` equal to the accumulator, and advances the pc by 1.
- R5: An opcode whose upper four bits are 1111 is two bytes long. Its immediate is requested at offset pc+1 in the same segment.
- R6: Opcode 0xF4 with immediate i sets the pc to pc+2+sext(i) when the accumulator is 0, and to pc+2 otherwise (sext is 8-bit two's complement, widened to 16 bits, modulo 2^16).
- R7: Opcode 0xF5 with immediate i always sets the pc to pc+2+sext(i).
- R8: Near call 0x07 sets the pc to pc+1+sext(acc) and writes the accumulator with (1 − acc) mod 256.
- R9: Far call 0x06 loads the code segment from the accumulator, sets the pc to 0, and writes the previous segment value into the accumulator. The segment changes for no other opcode.
- R10: Every other legal opcode raises `exec_valid` for one cycle with `exec_opcode`. For two-byte opcodes it also raises `exec_has_imm` with `exec_imm`. The pc then advances by the instruction length, and at most one of `exec_valid`, `print_valid`, `acc_wr_en` is high in any cycle.
- R11: Memory reads have one cycle of latency: `imem_rdata` in the cycle after a request holds the byte at the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req | output | 1 | Code memory read request |
| imem_addr | output | 24 | Read address {segment, pc offset} |
| imem_rdata | input | 8 | Read data, valid the cycle after a request |
| acc_in | input | 8 | Current accumulator value |
| acc_wr_en | output | 1 | Accumulator write strobe from a call |
| acc_wr_data | output | 8 | Value written to the accumulator |
| exec_valid | output | 1 | Strobe handing an opcode to the execution units |
| exec_opcode | output | 8 | Opcode being handed over |
| exec_imm | output | 8 | Immediate byte of a two-byte opcode |
| exec_has_imm | output | 1 | The handed-over opcode carries an immediate |
| print_valid | output | 1 | Debug print strobe |
| print_data | output | 8 | Accumulator value to print |
| halted | output | 1 | Sticky stop indicator |
| pc_o | output | 16 | Current program counter |
| code_seg_o | output | 8 | Current code segment |

## Verification
A wrong classification or a wrong next-pc value becomes visible within one instruction. The next request goes to the wrong address, so the halting pc, the strobe counts or the final segment differ from the arithmetic expectation a few cycles later. Every opcode runs from a program whose surrounding bytes are zero, so the machine halts exactly at the target it computed, and the sweeps over all immediates and all accumulator values expose any sign-extension or length error in the final pc. A halted state that leaks shows up as a memory request or strobe counted after `halted` rose.

// File: rtl/accseq_pkg.sv
`timescale 1ns/1ps
package accseq_pkg;

   typedef enum logic [3:0] {
      OC_STOP,
      OC_NOP,
      OC_PRINT,
      OC_FAR,
      OC_NEAR,
      OC_BEZ,
      OC_JMP,
      OC_EXEC,
      OC_BAD
   } opclass_e;

   typedef enum logic [2:0] {
      NX_HOLD,
      NX_INC1,
      NX_INC2,
      NX_REL1,
      NX_REL2,
      NX_ZERO
   } nextpc_e;

   typedef enum logic [1:0] {
      ST_FETCH,
      ST_DECODE,
      ST_IMM,
      ST_HALT
   } seqstate_e;

endpackage

// File: rtl/accseq_decode.sv
`timescale 1ns/1ps
module accseq_decode
   import accseq_pkg::*;
#(
   parameter int OPW = 8
) (
   input  logic [OPW-1:0] op,
   output opclass_e       cls,
   output logic           two_byte
);

   if (OPW != 8) begin : g_bad_opw
      $error("accseq_decode: opcode encoding needs OPW == 8");
   end

   assign two_byte = (op[OPW-1 -: 4] == 4'hF);

   always_comb begin
      casez (op)
         8'h00:        cls = OC_STOP;
         8'h01:        cls = OC_NOP;
         8'h02:        cls = OC_PRINT;
         8'h06:        cls = OC_FAR;
         8'h07:        cls = OC_NEAR;
         8'hF4:        cls = OC_BEZ;
         8'hF5:        cls = OC_JMP;
         8'b0000_010?: cls = OC_BAD;
         8'h13:        cls = OC_BAD;
         8'b0001_01??: cls = OC_BAD;
         8'h1B:        cls = OC_BAD;
         8'b0001_11??: cls = OC_BAD;
         8'b110?_????: cls = OC_BAD;
         8'b1111_011?: cls = OC_BAD;
         8'b1111_10??: cls = OC_BAD;
         8'b1111_110?: cls = OC_BAD;
         8'hFF:        cls = OC_BAD;
         default:      cls = OC_EXEC;
      endcase
   end

endmodule

// File: rtl/accseq_target.sv
`timescale 1ns/1ps
module accseq_target
   import accseq_pkg::*;
#(
   parameter int PC_W  = 16,
   parameter int OFF_W = 8
) (
   input  logic [PC_W-1:0]  pc,
   input  nextpc_e          mode,
   input  logic [OFF_W-1:0] off,
   output logic [PC_W-1:0]  nxt
);

   localparam int EXT_W = PC_W - OFF_W;

   if (EXT_W < 1) begin : g_bad_width
      $error("accseq_target: PC_W must exceed OFF_W");
   end

   logic [PC_W-1:0] sx;

   if (EXT_W > 0) begin : g_sext
      assign sx = {{EXT_W{off[OFF_W-1]}}, off};
   end else begin : g_trunc
      assign sx = off[PC_W-1:0];
   end

   always_comb begin
      case (mode)
         NX_INC1: nxt = pc + PC_W'(1);
         NX_INC2: nxt = pc + PC_W'(2);
         NX_REL1: nxt = pc + PC_W'(1) + sx;
         NX_REL2: nxt = pc + PC_W'(2) + sx;
         NX_ZERO: nxt = '0;
         default: nxt = pc;
      endcase
   end

endmodule

// File: rtl/accseq_segreg.sv
`timescale 1ns/1ps
module accseq_segreg #(
   parameter int SEG_W     = 8,
   parameter int DW        = 8,
   parameter int RESET_SEG = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [DW-1:0]    ld_data,
   output logic [SEG_W-1:0] seg,
   output logic [DW-1:0]    seg_ext
);

   if (SEG_W > DW) begin : g_bad_seg
      $error("accseq_segreg: SEG_W may not exceed DW");
   end
   if (RESET_SEG >= (1 << SEG_W)) begin : g_bad_rst
      $error("accseq_segreg: RESET_SEG does not fit SEG_W");
   end

   logic [SEG_W-1:0] seg_q;
   logic [SEG_W-1:0] ld_val;

   if (SEG_W == DW) begin : g_full
      assign ld_val  = ld_data;
      assign seg_ext = seg_q;
   end else begin : g_narrow
      assign ld_val  = ld_data[SEG_W-1:0];
      assign seg_ext = {{(DW-SEG_W){1'b0}}, seg_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  seg_q <= SEG_W'(RESET_SEG);
      else if (ld) seg_q <= ld_val;
   end

   assign seg = seg_q;

   p_seg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(seg));
   p_seg_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> seg == $past(ld_data[SEG_W-1:0]));

endmodule

// File: rtl/accseq_fetch.sv
`timescale 1ns/1ps
module accseq_fetch
   import accseq_pkg::*;
#(
   parameter int PC_W      = 16,
   parameter int SEG_W     = 8,
   parameter int DW        = 8,
   parameter int RESET_SEG = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   output logic                  imem_req,
   output logic [SEG_W+PC_W-1:0] imem_addr,
   input  logic [DW-1:0]         imem_rdata,
   input  logic [DW-1:0]         acc_in,
   output logic                  acc_wr_en,
   output logic [DW-1:0]         acc_wr_data,
   output logic                  exec_valid,
   output logic [DW-1:0]         exec_opcode,
   output logic [DW-1:0]         exec_imm,
   output logic                  exec_has_imm,
   output logic                  print_valid,
   output logic [DW-1:0]         print_data,
   output logic                  halted,
   output logic [PC_W-1:0]       pc_o,
   output logic [SEG_W-1:0]      code_seg_o
);

   if (DW != 8) begin : g_bad_dw
      $error("accseq_fetch: the opcode map needs DW == 8");
   end

   seqstate_e       state_q, state_d;
   logic [PC_W-1:0] pc_q, pc_nxt, fetch_pc;
   logic [DW-1:0]   op_q, op_sel, off_sel, seg_ext;
   nextpc_e         nx_mode;
   opclass_e        cls;
   logic            two_byte, seg_ld;

   assign op_sel = (state_q == ST_IMM) ? op_q : imem_rdata;

   accseq_decode #(.OPW(DW)) u_decode (
      .op       (op_sel),
      .cls      (cls),
      .two_byte (two_byte)
   );

   accseq_target #(.PC_W(PC_W), .OFF_W(DW)) u_target (
      .pc   (pc_q),
      .mode (nx_mode),
      .off  (off_sel),
      .nxt  (pc_nxt)
   );

   accseq_segreg #(.SEG_W(SEG_W), .DW(DW), .RESET_SEG(RESET_SEG)) u_seg (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (seg_ld),
      .ld_data (acc_in),
      .seg     (code_seg_o),
      .seg_ext (seg_ext)
   );

   always_comb begin
      state_d      = state_q;
      nx_mode      = NX_HOLD;
      off_sel      = acc_in;
      seg_ld       = 1'b0;
      imem_req     = 1'b0;
      fetch_pc     = pc_q;
      acc_wr_en    = 1'b0;
      acc_wr_data  = '0;
      exec_valid   = 1'b0;
      exec_has_imm = 1'b0;
      exec_imm     = '0;
      print_valid  = 1'b0;
      case (state_q)
         ST_FETCH: begin
            imem_req = 1'b1;
            state_d  = ST_DECODE;
         end
         ST_DECODE: begin
            state_d = ST_FETCH;
            case (cls)
               OC_STOP, OC_BAD: state_d = ST_HALT;
               OC_NOP: nx_mode = NX_INC1;
               OC_PRINT: begin
                  print_valid = 1'b1;
                  nx_mode     = NX_INC1;
               end
               OC_FAR: begin
                  seg_ld      = 1'b1;
                  nx_mode     = NX_ZERO;
                  acc_wr_en   = 1'b1;
                  acc_wr_data = seg_ext;
               end
               OC_NEAR: begin
                  nx_mode     = NX_REL1;
                  acc_wr_en   = 1'b1;
                  acc_wr_data = DW'(1) - acc_in;
               end
               OC_BEZ, OC_JMP: begin
                  imem_req = 1'b1;
                  fetch_pc = pc_q + PC_W'(1);
                  state_d  = ST_IMM;
               end
               default: begin
                  if (two_byte) begin
                     imem_req = 1'b1;
                     fetch_pc = pc_q + PC_W'(1);
                     state_d  = ST_IMM;
                  end else begin
                     exec_valid = 1'b1;
                     nx_mode    = NX_INC1;
                  end
               end
            endcase
         end
         ST_IMM: begin
            state_d = ST_FETCH;
            off_sel = imem_rdata;
            case (cls)
               OC_BEZ:  nx_mode = (acc_in == '0) ? NX_REL2 : NX_INC2;
               OC_JMP:  nx_mode = NX_REL2;
               default: begin
                  exec_valid   = 1'b1;
                  exec_has_imm = 1'b1;
                  exec_imm     = imem_rdata;
                  nx_mode      = NX_INC2;
               end
            endcase
         end
         default: state_d = ST_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FETCH;
         pc_q    <= '0;
         op_q    <= '0;
      end else begin
         state_q <= state_d;
         pc_q    <= pc_nxt;
         if (state_q == ST_DECODE) op_q <= imem_rdata;
      end
   end

   assign imem_addr   = {code_seg_o, fetch_pc};
   assign exec_opcode = op_sel;
   assign print_data  = acc_in;
   assign halted      = (state_q == ST_HALT);
   assign pc_o        = pc_q;

   p_halt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   p_halt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !imem_req && !exec_valid && !print_valid && !acc_wr_en);
   p_halt_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> $stable(pc_o));
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exec_valid, print_valid, acc_wr_en}));
   p_imm_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_has_imm |-> $past(imem_req));
   p_bez_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IMM && op_q == 8'hF4 && acc_in != '0)
      |=> pc_o == $past(pc_o) + PC_W'(2));

endmodule

// File: tb/accseq_fetch_tb.sv
`timescale 1ns/1ps
module accseq_fetch_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imem_req;
   logic [23:0] imem_addr;
   logic [7:0]  imem_rdata = 8'h00;
   logic [7:0]  acc_in = 8'h00;
   logic        acc_wr_en, exec_valid, exec_has_imm, print_valid, halted;
   logic [7:0]  acc_wr_data, exec_opcode, exec_imm, print_data, code_seg_o;
   logic [15:0] pc_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   logic [7:0] cur_op = 8'h00;
   logic [7:0] cur_imm = 8'h00;

   int          req_cnt, exec_cnt, print_cnt, accw_cnt, quiet_bad;
   logic [23:0] req_addr1;
   logic [7:0]  ex_op, ex_imm, pr_data, aw_data;
   logic        ex_hi;

   always #2.5 clk = ~clk;

   accseq_fetch u_dut (
      .clk(clk), .rst_n(rst_n), .imem_req(imem_req), .imem_addr(imem_addr),
      .imem_rdata(imem_rdata), .acc_in(acc_in), .acc_wr_en(acc_wr_en),
      .acc_wr_data(acc_wr_data), .exec_valid(exec_valid),
      .exec_opcode(exec_opcode), .exec_imm(exec_imm),
      .exec_has_imm(exec_has_imm), .print_valid(print_valid),
      .print_data(print_data), .halted(halted), .pc_o(pc_o),
      .code_seg_o(code_seg_o)
   );

   // Code memory model (R11): one cycle of read latency.
   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      if (a[23:16] != 8'h01) return 8'h00;
      if (a[15:0] == 16'h0000) return cur_op;
      if (a[15:0] == 16'h0001) return cur_imm;
      return 8'h00;
   endfunction

   always @(posedge clk) if (imem_req) imem_rdata <= mem_byte(imem_addr);

   always @(negedge clk) begin
      if (rst_n) begin
         if (halted && (imem_req || exec_valid || print_valid || acc_wr_en))
            quiet_bad++;
         if (imem_req) begin
            if (req_cnt == 1) req_addr1 = imem_addr;
            req_cnt++;
         end
         if (exec_valid) begin
            exec_cnt++; ex_op = exec_opcode; ex_imm = exec_imm; ex_hi = exec_has_imm;
         end
         if (print_valid) begin print_cnt++; pr_data = print_data; end
         if (acc_wr_en) begin accw_cnt++; aw_data = acc_wr_data; end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 190000) begin
         failures++;
         $display("FAIL watchdog: run did not finish actual=%0d expected<=190000", cycles);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (op=%0h imm=%0h acc=%0h)",
                  req, act, exp, cur_op, cur_imm, acc_in);
      end
   endtask

   task automatic run_prog(input logic [7:0] op, input logic [7:0] imm,
                           input logic [7:0] acc, input bit rst_chk);
      @(posedge clk); #1;
      rst_n = 1'b0; cur_op = op; cur_imm = imm; acc_in = acc;
      repeat (2) @(posedge clk);
      #1;
      req_cnt = 0; exec_cnt = 0; print_cnt = 0; accw_cnt = 0; quiet_bad = 0;
      req_addr1 = '0; ex_op = '0; ex_imm = '0; ex_hi = 1'b0; pr_data = '0; aw_data = '0;
      rst_n = 1'b1;
      #1;
      if (rst_chk) begin
         chk(pc_o == 16'h0000, "R1 pc", pc_o, 0);
         chk(code_seg_o == 8'h01, "R1 seg", code_seg_o, 1);
         chk(halted == 1'b0, "R1 halted", halted, 0);
         chk(imem_req && imem_addr == 24'h010000, "R1 first addr", imem_addr, 24'h010000);
      end
      repeat (14) @(posedge clk);
      #1;
   endtask

   // Kinds: 0 halt, 1 nop, 2 print, 3 far, 4 near, 5 bez, 6 jmp, 7 exec1, 8 exec2
   function automatic int kind_of(input int op);
      if (op == 0 || op == 4 || op == 5 || op == 'h13 || (op >= 'h14 && op <= 'h17) ||
          op == 'h1B || (op >= 'h1C && op <= 'h1F) || (op >= 'hC0 && op <= 'hDF) ||
          (op >= 'hF6 && op <= 'hFD) || op == 'hFF) return 0;
      if (op == 1) return 1;
      if (op == 2) return 2;
      if (op == 6) return 3;
      if (op == 7) return 4;
      if (op == 'hF4) return 5;
      if (op == 'hF5) return 6;
      if (op >= 'hF0) return 8;
      return 7;
   endfunction

   function automatic logic [15:0] sx16(input logic [7:0] v);
      return {{8{v[7]}}, v};
   endfunction

   initial begin
      logic [15:0] tgt;
      int k;
      int exp_pc;
      run_prog(8'h01, 8'h00, 8'h00, 1'b1);
      chk(pc_o == 16'h0001, "R3 nop pc", pc_o, 1);

      // Whole opcode map with acc=0x3C, immediate 0
      for (int op = 0; op < 256; op++) begin
         run_prog(op[7:0], 8'h00, 8'h3C, 1'b0);
         k = kind_of(op);
         case (k)
            0: exp_pc = 0;
            1, 2, 7: exp_pc = 1;
            3: exp_pc = 0;
            4: exp_pc = 'h3D;
            default: exp_pc = 2;
         endcase
         chk(pc_o == exp_pc[15:0], (k == 0) ? "R2 halt pc" : "R10 final pc", pc_o, exp_pc);
         chk(halted, "R2 halted", halted, 1);
         chk(quiet_bad == 0, "R2 quiet after halt", quiet_bad, 0);
         chk(exec_cnt == ((k == 7 || k == 8) ? 1 : 0), "R10 exec count", exec_cnt, (k == 7 || k == 8));
         if (k == 7 || k == 8) begin
            chk(ex_op == op[7:0], "R10 opcode", ex_op, op);
            chk(ex_hi == (k == 8), "R10 has_imm", ex_hi, (k == 8));
         end
         chk(print_cnt == ((k == 2) ? 1 : 0), "R4 print count", print_cnt, (k == 2));
         if (k == 2) chk(pr_data == 8'h3C, "R4 print data", pr_data, 8'h3C);
         chk(accw_cnt == ((k == 3 || k == 4) ? 1 : 0), "R8 acc write count", accw_cnt, (k == 3 || k == 4));
         if (k == 4) chk(aw_data == 8'hC5, "R8 near return", aw_data, 8'hC5);
         if (k == 3) chk(aw_data == 8'h01, "R9 far return", aw_data, 1);
         chk(code_seg_o == ((k == 3) ? 8'h3C : 8'h01), "R9 segment", code_seg_o, (k == 3) ? 'h3C : 1);
         if (k >= 5 && k != 7) chk(req_addr1 == 24'h010001, "R5 imm addr", req_addr1, 24'h010001);
         if (k == 0) chk(req_cnt == 1, "R2 no imm fetch", req_cnt, 1);
         if (k == 1) chk(exec_cnt + print_cnt + accw_cnt == 0, "R3 no strobe", exec_cnt + print_cnt + accw_cnt, 0);
      end

      // Immediate sweep for branch, jump and a two-byte exec opcode
      for (int i = 0; i < 256; i++) begin
         tgt = 16'h0002 + sx16(i[7:0]);
         run_prog(8'hF0, i[7:0], 8'h3C, 1'b0);
         chk(pc_o == 16'h0002, "R5 two-byte length", pc_o, 2);
         chk(exec_cnt == 1 && ex_imm == i[7:0], "R10 exec imm", ex_imm, i);
         run_prog(8'hF4, i[7:0], 8'h3C, 1'b0);
         chk(pc_o == 16'h0002, "R6 not taken", pc_o, 2);
         if (tgt != 16'h0000) begin
            run_prog(8'hF4, i[7:0], 8'h00, 1'b0);
            chk(pc_o == tgt, "R6 taken", pc_o, tgt);
            run_prog(8'hF5, i[7:0], 8'h91, 1'b0);
            chk(pc_o == tgt, "R7 jump", pc_o, tgt);
         end
      end

      // Accumulator sweep for both calls and print
      for (int a = 0; a < 256; a++) begin
         tgt = 16'h0001 + sx16(a[7:0]);
         if (tgt != 16'h0000) begin
            run_prog(8'h07, 8'h00, a[7:0], 1'b0);
            chk(pc_o == tgt, "R8 near target", pc_o, tgt);
            chk(accw_cnt == 1 && aw_data == 8'(1 - a), "R8 near return", aw_data, 8'(1 - a));
         end
         if (a != 1) begin
            run_prog(8'h06, 8'h00, a[7:0], 1'b0);
            chk(code_seg_o == a[7:0] && pc_o == 16'h0000, "R9 far target", {code_seg_o, pc_o}, a << 16);
            chk(accw_cnt == 1 && aw_data == 8'h01, "R9 far return", aw_data, 1);
         end
         if (a % 37 == 0) begin
            run_prog(8'h02, 8'h00, a[7:0], 1'b0);
            chk(print_cnt == 1 && pr_data == a[7:0], "R4 print data", pr_data, a);
         end
      end

      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule